// File: doc/BRIEF.md
# UART Hardware Flow Control Unit

This block handles hardware handshaking for one UART channel. It watches the receive FIFO fill level and raises the request-to-send line when the FIFO is close to full. It can also stop new transmit characters from starting while the far end holds clear-to-send inactive. The serializer, the deserializer, the FIFOs and the baud generator sit outside this block. They appear only as a level, a stop-bit strobe, a start request and a start grant.

The RTS line asserts only on a received stop bit, and only when the fill level has reached a halt threshold. It deasserts as soon as the level has drained to a separately chosen resume threshold. Each threshold is picked by its own 2-bit code. When RTS asserts, an interrupt can be raised. That interrupt stays pending until software reads the modem status register, which the block sees as a one-cycle read strobe.

On the transmit side, the sampled CTS level decides whether the serializer may begin its next character. A character that is already being shifted out is never cut short. The block only withholds the next start grant.

Top module: `uart_hwflow`

## Requirements
- R1: After reset, `rts_out`, `irq_out` and `cts_stat` are 0.
- R2: RTS-halt codes on `halt_sel` are 00=8, 01=16, 10=56, 11=60 entries. With `fifo_en` and `rts_auto_en` both 1 and `rts_out` at 0, a cycle that has `rx_stop_stb`=1 and `rx_level` at or above the halt threshold sets `rts_out` to 1 on the next clock.
- R3: Without `rx_stop_stb`, `rts_out` does not rise, even when the level is above the halt threshold.
- R4: Resume codes on `resume_sel` are 00=0, 01=8, 10=16, 11=56 entries. With `rts_out` at 1, a level at or below the resume threshold clears `rts_out` on the next clock, with no strobe needed. A level above the resume threshold keeps `rts_out` at 1.
- R5: When `rts_out` rises in a cycle where `rts_irq_en` was 1, `irq_out` becomes 1 on the same clock. With `rts_irq_en` at 0, `irq_out` stays 0.
- R6: `irq_out` stays 1 until `msr_rd_stb` is seen, and then returns to 0 on the next clock.
- R7: With `fifo_en` and `cts_auto_en` both 1, `cts_n` at 1 sets `cts_stat` to 1 on the next clock and forces `tx_start` to 0. `cts_n` at 0 lets `tx_start` follow `tx_req`.
- R8: When `fifo_en` or `cts_auto_en` is 0, `cts_stat` reads 0 from the next clock on, and `tx_start` follows `tx_req` whatever `cts_n` is.
- R9: Clearing `rts_auto_en` or `fifo_en` drives `rts_out` to 0 on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en | input | 1 | FIFOs enabled |
| rts_auto_en | input | 1 | Automatic RTS enable |
| cts_auto_en | input | 1 | Automatic CTS enable |
| rts_irq_en | input | 1 | Interrupt enable for an RTS rise |
| halt_sel | input | 2 | Halt threshold code |
| resume_sel | input | 2 | Resume threshold code |
| rx_level | input | LVL_W | Receive FIFO fill level |
| rx_stop_stb | input | 1 | Stop bit of a received character |
| cts_n | input | 1 | Clear-to-send pin, 1 = stop |
| tx_req | input | 1 | Serializer is ready to start the next character |
| msr_rd_stb | input | 1 | Modem status register read |
| rts_out | output | 1 | Request-to-send pin, 1 = halt sender |
| tx_start | output | 1 | Grant to start the next character |
| rts_stat | output | 1 | Automatic RTS halt status |
| cts_stat | output | 1 | CTS stop status |
| irq_out | output | 1 | RTS-change interrupt request |

## Verification
The assertions assume that `rx_stop_stb` and `msr_rd_stb` are single-cycle pulses. They also assume that `cts_n` is already synchronous to `clk`, and that the enables change only between characters. The bench drives every input on the falling edge, so each value is held stable across the rising edge that samples it. Strobes are raised for exactly one cycle. The bench never chooses a halt threshold that lies at or below the resume threshold, so RTS cannot rise and fall in back-to-back cycles.

// File: rtl/uart_hwflow.sv
module uart_hwflow #(
  parameter int LVL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic             rts_auto_en,
  input  logic             cts_auto_en,
  input  logic             rts_irq_en,
  input  logic [1:0]       halt_sel,
  input  logic [1:0]       resume_sel,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             rx_stop_stb,
  input  logic             cts_n,
  input  logic             tx_req,
  input  logic             msr_rd_stb,
  output logic             rts_out,
  output logic             tx_start,
  output logic             rts_stat,
  output logic             cts_stat,
  output logic             irq_out
);

  function automatic logic [LVL_W-1:0] halt_thr(input logic [1:0] s);
    case (s)
      2'd0:    return LVL_W'(8);
      2'd1:    return LVL_W'(16);
      2'd2:    return LVL_W'(56);
      default: return LVL_W'(60);
    endcase
  endfunction

  function automatic logic [LVL_W-1:0] resume_thr(input logic [1:0] s);
    case (s)
      2'd0:    return LVL_W'(0);
      2'd1:    return LVL_W'(8);
      2'd2:    return LVL_W'(16);
      default: return LVL_W'(56);
    endcase
  endfunction

  logic rts_q, irq_q, cts_q;

  wire rts_live = rts_auto_en & fifo_en;
  wire rts_set  = rts_live & ~rts_q & rx_stop_stb & (rx_level >= halt_thr(halt_sel));
  wire rts_clr  = rts_q & (~rts_live | (rx_level <= resume_thr(resume_sel)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rts_q <= 1'b0;
      irq_q <= 1'b0;
      cts_q <= 1'b0;
    end else begin
      if (rts_set)      rts_q <= 1'b1;
      else if (rts_clr) rts_q <= 1'b0;
      irq_q <= (rts_set & rts_irq_en) | (irq_q & ~msr_rd_stb);
      cts_q <= fifo_en & cts_auto_en & cts_n;
    end
  end

  assign rts_out  = rts_q;
  assign rts_stat = rts_q;
  assign cts_stat = cts_q;
  assign irq_out  = irq_q;
  assign tx_start = tx_req & ~cts_q;

endmodule

// File: rtl/uart_hwflow_chk.sv
module uart_hwflow_chk #(
  parameter int LVL_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fifo_en,
  input logic             cts_auto_en,
  input logic             rts_irq_en,
  input logic [LVL_W-1:0] rx_level,
  input logic             rx_stop_stb,
  input logic             msr_rd_stb,
  input logic             rts_out,
  input logic             tx_start,
  input logic             cts_stat,
  input logic             irq_out
);

  always @(posedge clk) begin
    if (rst_n) assert_lvl_known_R2: assert (!$isunknown(rx_level));
  end

  assert_rise_on_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rts_out) |-> $past(rx_stop_stb));

  assert_irq_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rts_out) && $past(rts_irq_en)) |-> irq_out);

  assert_irq_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_out) |-> $rose(rts_out));

  assert_irq_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_out) |-> $past(msr_rd_stb));

  assert_cts_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cts_stat |-> !tx_start);

  assert_cts_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en || !cts_auto_en) |=> !cts_stat);

endmodule

bind uart_hwflow uart_hwflow_chk #(.LVL_W(LVL_W)) u_chk (.*);

// File: tb/sim_uart_hwflow.sv
module sim_uart_hwflow;
  localparam int LVL_W = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_en = 1'b0, rts_auto_en = 1'b0, cts_auto_en = 1'b0, rts_irq_en = 1'b0;
  logic [1:0] halt_sel = 2'd0, resume_sel = 2'd0;
  logic [LVL_W-1:0] rx_level = '0;
  logic rx_stop_stb = 1'b0, cts_n = 1'b0, tx_req = 1'b0, msr_rd_stb = 1'b0;
  logic rts_out, tx_start, rts_stat, cts_stat, irq_out;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  uart_hwflow #(.LVL_W(LVL_W)) u0 (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .rts_auto_en(rts_auto_en),
    .cts_auto_en(cts_auto_en), .rts_irq_en(rts_irq_en), .halt_sel(halt_sel),
    .resume_sel(resume_sel), .rx_level(rx_level), .rx_stop_stb(rx_stop_stb),
    .cts_n(cts_n), .tx_req(tx_req), .msr_rd_stb(msr_rd_stb), .rts_out(rts_out),
    .tx_start(tx_start), .rts_stat(rts_stat), .cts_stat(cts_stat), .irq_out(irq_out)
  );

  // vector: halt_sel, resume_sel, level, stop strobe, expected rts
  typedef struct packed {
    logic [1:0] hs;
    logic [1:0] rs;
    logic [LVL_W-1:0] lvl;
    logic stb;
    logic exp;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 2'd0, 9'd7,  1'b1, 1'b0},
    '{2'd0, 2'd0, 9'd8,  1'b0, 1'b0},
    '{2'd0, 2'd0, 9'd8,  1'b1, 1'b1},
    '{2'd0, 2'd0, 9'd1,  1'b0, 1'b1},
    '{2'd0, 2'd0, 9'd0,  1'b0, 1'b0},
    '{2'd1, 2'd1, 9'd15, 1'b1, 1'b0},
    '{2'd1, 2'd1, 9'd16, 1'b1, 1'b1},
    '{2'd1, 2'd1, 9'd9,  1'b0, 1'b1},
    '{2'd1, 2'd1, 9'd8,  1'b0, 1'b0},
    '{2'd2, 2'd2, 9'd55, 1'b1, 1'b0},
    '{2'd2, 2'd2, 9'd56, 1'b1, 1'b1},
    '{2'd2, 2'd2, 9'd17, 1'b1, 1'b1},
    '{2'd2, 2'd2, 9'd16, 1'b0, 1'b0},
    '{2'd3, 2'd3, 9'd59, 1'b1, 1'b0},
    '{2'd3, 2'd3, 9'd60, 1'b1, 1'b1},
    '{2'd3, 2'd3, 9'd57, 1'b0, 1'b1},
    '{2'd3, 2'd3, 9'd56, 1'b0, 1'b0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  initial begin
    fork
      begin
        repeat (5000) @(posedge clk);
        if (!done) begin
          errors++;
          checks++;
          $display("FAIL watchdog actual=timeout expected=finish");
          $display("Result: errors=%0d of %0d checks", errors, checks);
          $finish;
        end
      end
    join_none

    repeat (3) tick();
    rst_n = 1'b1;
    tx_req = 1'b1;
    tick();
    // R1 reset state
    check(rts_out == 1'b0, "R1 rts", rts_out, 0);
    check(irq_out == 1'b0, "R1 irq", irq_out, 0);
    check(cts_stat == 1'b0, "R1 cts_stat", cts_stat, 0);

    // table walk: R2 halt codes, R3 no strobe, R4 resume codes, R5 irq off
    fifo_en = 1'b1;
    rts_auto_en = 1'b1;
    for (int i = 0; i < NV; i++) begin
      halt_sel = VECS[i].hs;
      resume_sel = VECS[i].rs;
      rx_level = VECS[i].lvl;
      rx_stop_stb = VECS[i].stb;
      tick();
      rx_stop_stb = 1'b0;
      check(rts_out == VECS[i].exp, "R2/R3/R4 table rts", rts_out, VECS[i].exp);
      check(rts_stat == rts_out, "R2 rts_stat", rts_stat, rts_out);
      check(irq_out == 1'b0, "R5 irq disabled", irq_out, 0);
    end

    // R5 irq on rise, R6 held until read
    rts_irq_en = 1'b1;
    halt_sel = 2'd0;
    resume_sel = 2'd0;
    rx_level = 9'd20;
    rx_stop_stb = 1'b1;
    tick();
    rx_stop_stb = 1'b0;
    check(rts_out == 1'b1, "R5 rts rise", rts_out, 1);
    check(irq_out == 1'b1, "R5 irq set", irq_out, 1);
    repeat (3) tick();
    check(irq_out == 1'b1, "R6 irq held", irq_out, 1);
    msr_rd_stb = 1'b1;
    tick();
    msr_rd_stb = 1'b0;
    check(irq_out == 1'b0, "R6 irq cleared", irq_out, 0);
    check(rts_out == 1'b1, "R6 rts unaffected", rts_out, 1);

    // R9 disabling auto RTS forces RTS low
    rts_auto_en = 1'b0;
    tick();
    check(rts_out == 1'b0, "R9 rts forced low", rts_out, 0);
    rts_auto_en = 1'b1;
    rx_stop_stb = 1'b1;
    tick();
    rx_stop_stb = 1'b0;
    check(rts_out == 1'b1, "R9 rts back", rts_out, 1);
    msr_rd_stb = 1'b1;
    fifo_en = 1'b0;
    tick();
    msr_rd_stb = 1'b0;
    check(rts_out == 1'b0, "R9 fifo off low", rts_out, 0);
    fifo_en = 1'b1;
    rx_level = '0;

    // R7 CTS gating
    cts_auto_en = 1'b1;
    cts_n = 1'b1;
    tick();
    check(cts_stat == 1'b1, "R7 cts_stat", cts_stat, 1);
    check(tx_start == 1'b0, "R7 tx blocked", tx_start, 0);
    tx_req = 1'b0;
    tick();
    check(tx_start == 1'b0, "R7 no req", tx_start, 0);
    tx_req = 1'b1;
    cts_n = 1'b0;
    tick();
    check(cts_stat == 1'b0, "R7 cts_stat low", cts_stat, 0);
    check(tx_start == 1'b1, "R7 tx allowed", tx_start, 1);

    // R8 disables
    cts_n = 1'b1;
    cts_auto_en = 1'b0;
    tick();
    check(cts_stat == 1'b0, "R8 auto off stat", cts_stat, 0);
    check(tx_start == 1'b1, "R8 auto off tx", tx_start, 1);
    cts_auto_en = 1'b1;
    fifo_en = 1'b0;
    tick();
    check(cts_stat == 1'b0, "R8 fifo off stat", cts_stat, 0);
    check(tx_start == 1'b1, "R8 fifo off tx", tx_start, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule